// File: doc/BRIEF.md
# Accumulator Status Cell Register

This block is the storage register of one cell in a grid of identical cells, together with the logic that decides whether the cell is acting as an accumulator. The word is NLEN+12 bits wide. From bit 0 upward it holds these fields: the accumulator flag `a`, the origin flag `p`, predecessor bits `q2,q1`, successor bits `s2,s1`, order bits `i3,i2,i1`, direction bits `d2,d1`, and a length/number field `y0..yn`. One clock edge completes one time-step.

Three kinds of write can reach the word in a step:
- a phase-one external load;
- up to NPORT simultaneous phase-three stores, which are merged by bitwise OR;
- a numeric write-back from the accumulator arithmetic.

Accumulator status is sticky. It is entered when a load or store writes a word whose `(p,a)` pair is `(0,1)`. While the status is held, the cell keeps its successor direction in a separate saved-direction register. The cell also reports whether activity arriving at it must be forwarded to its successor.

Top module: `cell_acc_reg`

## Requirements
- R1: After synchronous reset the word is 0, accumulator status is off and `succ_dir` is 0. In a step with no load, no valid store and no numeric write, the word and the status do not change.
- R2: A load or an accepted store whose word has p (bit 1) = 0 and a (bit 0) = 1 turns accumulator status on. In the same step it copies {s1 (bit 5), s2 (bit 4)} into the saved-direction register.
- R3: `origin_mode` is 1 exactly when p (bit 1) of the word is 1 and the cell is not an accumulator. A word with p = 1 never turns accumulator status on.
- R4: `succ_dir` equals the saved-direction register while accumulator status is on. Otherwise it equals {s1, s2} of the current word.
- R5: While accumulator status is on, a merged store is accepted only if its a = 0 or its p = 1, and acceptance clears the status. Any other store leaves the word and the status unchanged.
- R6: A load has priority over stores and numeric writes in the same step, and the loaded word is what the cell holds after the step. A load whose (p,a) is not (0,1) returns an accumulator cell to normal status.
- R7: Simultaneous valid stores are merged bit by bit: a result bit is 1 when any valid incoming word has that bit set. Words on ports whose valid is 0 do not contribute.
- R8: `fwd_req` is 1 exactly when the cell is an accumulator or has origin status.
- R9: `acc_neg` is the top bit yn (bit NLEN+11) of the word while accumulator status is on, and 0 otherwise.
- R10: A numeric write with no load and no valid store replaces the word only while accumulator status is on. It keeps the status and the saved direction whatever its (p,a) bits are. It has no effect on a normal cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per time-step |
| rst | input | 1 | Synchronous active-high reset |
| in_load | input | 1 | Phase-one external load request |
| in_word | input | NLEN+12 | Word for the external load |
| st_valid | input | NPORT | Per-port store valid |
| st_word | input | NPORT*(NLEN+12) | Store words, port k in slice k |
| num_wr | input | 1 | Numeric write-back from accumulator arithmetic |
| num_word | input | NLEN+12 | Numeric write-back value |
| word_q | output | NLEN+12 | Stored word |
| acc_mode | output | 1 | Accumulator status |
| origin_mode | output | 1 | Origin status |
| succ_dir | output | 2 | Effective successor direction {s1,s2} |
| fwd_req | output | 1 | Incoming activity must be passed to the successor |
| acc_neg | output | 1 | Sign of the accumulator number |

## Verification
The hardest state to reach is an accumulator whose saved direction differs from the successor bits of its current word. Only a numeric write-back can produce it, because loads and stores both recopy the direction. The bench first enters accumulator status with a load, then writes a number with different bits 5:4 and p = 1. It then shows that `succ_dir`, `origin_mode` and the status all ignore that number. Rejected stores are reached by sweeping every (p,a) pair and successor code over one-port and multi-port merges, starting from both a normal cell and an accumulator cell.

// File: rtl/cell_acc_pkg.sv
package cell_acc_pkg;

    localparam int CTRL_W = 11;
    localparam int BIT_A  = 0;
    localparam int BIT_P  = 1;

    typedef struct packed {
        logic d1;
        logic d2;
        logic i1;
        logic i2;
        logic i3;
        logic s1;
        logic s2;
        logic q1;
        logic q2;
        logic p;
        logic a;
    } ctrl_t;

    typedef enum logic [2:0] {
        UPD_HOLD,
        UPD_INPUT,
        UPD_STORE,
        UPD_DROP,
        UPD_NUM
    } upd_kind_t;

    function automatic logic is_acc_code(input ctrl_t c);
        return (!c.p) && c.a;
    endfunction

    function automatic logic [1:0] dir_of(input ctrl_t c);
        return {c.s1, c.s2};
    endfunction

endpackage

// File: rtl/cell_store_merge.sv
module cell_store_merge
    import cell_acc_pkg::*;
#(
    parameter int W     = 16,
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0]   valid,
    input  logic [NPORT*W-1:0] words,
    output logic               any,
    output logic [W-1:0]       merged
);

    logic [W-1:0] masked [NPORT];

    for (genvar k = 0; k < NPORT; k++) begin : g_mask
        assign masked[k] = valid[k] ? words[k*W +: W] : '0;
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < NPORT; k++) begin
            merged = merged | masked[k];
        end
    end

    assign any = |valid;

endmodule

// File: rtl/cell_status_next.sv
module cell_status_next
    import cell_acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_word,
    input  logic         cur_acc,
    input  logic [1:0]   cur_dir,
    input  logic         in_load,
    input  logic [W-1:0] in_word,
    input  logic         st_any,
    input  logic [W-1:0] st_merged,
    input  logic         num_wr,
    input  logic [W-1:0] num_word,
    output logic [W-1:0] nxt_word,
    output logic         nxt_acc,
    output logic [1:0]   nxt_dir,
    output upd_kind_t    kind
);

    ctrl_t in_ctrl;
    ctrl_t st_ctrl;

    assign in_ctrl = ctrl_t'(in_word[CTRL_W-1:0]);
    assign st_ctrl = ctrl_t'(st_merged[CTRL_W-1:0]);

    always_comb begin
        nxt_word = cur_word;
        nxt_acc  = cur_acc;
        nxt_dir  = cur_dir;
        kind     = UPD_HOLD;
        if (in_load) begin
            kind     = UPD_INPUT;
            nxt_word = in_word;
            nxt_acc  = is_acc_code(in_ctrl);
            if (is_acc_code(in_ctrl)) begin
                nxt_dir = dir_of(in_ctrl);
            end
        end else if (st_any) begin
            if (cur_acc && is_acc_code(st_ctrl)) begin
                kind = UPD_DROP;
            end else begin
                kind     = UPD_STORE;
                nxt_word = st_merged;
                nxt_acc  = is_acc_code(st_ctrl);
                if (is_acc_code(st_ctrl)) begin
                    nxt_dir = dir_of(st_ctrl);
                end
            end
        end else if (num_wr && cur_acc) begin
            kind     = UPD_NUM;
            nxt_word = num_word;
        end
    end

endmodule

// File: rtl/cell_acc_reg.sv
module cell_acc_reg
    import cell_acc_pkg::*;
#(
    parameter int NLEN  = 4,
    parameter int NPORT = 4,
    localparam int W    = NLEN + 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_load,
    input  logic [W-1:0]       in_word,
    input  logic [NPORT-1:0]   st_valid,
    input  logic [NPORT*W-1:0] st_word,
    input  logic               num_wr,
    input  logic [W-1:0]       num_word,
    output logic [W-1:0]       word_q,
    output logic               acc_mode,
    output logic               origin_mode,
    output logic [1:0]         succ_dir,
    output logic               fwd_req,
    output logic               acc_neg
);

    logic             st_any;
    logic [W-1:0]     st_merged;
    logic [W-1:0]     nxt_word;
    logic             nxt_acc;
    logic [1:0]       nxt_dir;
    logic [1:0]       dir_q;
    upd_kind_t        kind;
    ctrl_t            cur_ctrl;

    cell_store_merge #(.W(W), .NPORT(NPORT)) u_merge (
        .valid  (st_valid),
        .words  (st_word),
        .any    (st_any),
        .merged (st_merged)
    );

    cell_status_next #(.W(W)) u_next (
        .cur_word  (word_q),
        .cur_acc   (acc_mode),
        .cur_dir   (dir_q),
        .in_load   (in_load),
        .in_word   (in_word),
        .st_any    (st_any),
        .st_merged (st_merged),
        .num_wr    (num_wr),
        .num_word  (num_word),
        .nxt_word  (nxt_word),
        .nxt_acc   (nxt_acc),
        .nxt_dir   (nxt_dir),
        .kind      (kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            acc_mode <= 1'b0;
            dir_q    <= 2'b00;
        end else begin
            word_q   <= nxt_word;
            acc_mode <= nxt_acc;
            dir_q    <= nxt_dir;
        end
    end

    assign cur_ctrl    = ctrl_t'(word_q[CTRL_W-1:0]);
    assign origin_mode = cur_ctrl.p && !acc_mode;
    assign succ_dir    = acc_mode ? dir_q : dir_of(cur_ctrl);
    assign fwd_req     = acc_mode || origin_mode;
    assign acc_neg     = acc_mode && word_q[W-1];

endmodule

// File: rtl/cell_acc_reg_chk.sv
module cell_acc_reg_chk
    import cell_acc_pkg::*;
#(
    parameter int W     = 16,
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_load,
    input logic [W-1:0]     in_word,
    input logic [NPORT-1:0] st_valid,
    input logic             num_wr,
    input logic [W-1:0]     num_word,
    input logic [W-1:0]     st_merged,
    input logic [W-1:0]     word_q,
    input logic             acc_mode,
    input logic [1:0]       succ_dir,
    input upd_kind_t        kind
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_load && st_valid == '0 && !num_wr) |=> ($stable(word_q) && $stable(acc_mode))); // R1

    AST_ENTER_ACC: assert property (@(posedge clk) disable iff (rst)
        (!acc_mode && !in_load && st_valid != '0 && st_merged[1:0] == 2'b01) |=> acc_mode); // R2

    AST_DIR_KEPT: assert property (@(posedge clk) disable iff (rst)
        (acc_mode && !in_load && st_valid == '0) |=> (acc_mode && $stable(succ_dir))); // R4

    AST_STORE_DROP: assert property (@(posedge clk) disable iff (rst)
        (acc_mode && !in_load && st_valid != '0 && st_merged[1:0] == 2'b01) |=> ($stable(word_q) && acc_mode)); // R5

    AST_DROP_KIND: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_DROP) |=> $stable(word_q)); // R5

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        in_load |=> (word_q == $past(in_word))); // R6

    AST_NUM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_mode && num_wr && !in_load && st_valid == '0) |=> (acc_mode && word_q == $past(num_word))); // R10

endmodule

bind cell_acc_reg cell_acc_reg_chk #(.W(W), .NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_load   (in_load),
    .in_word   (in_word),
    .st_valid  (st_valid),
    .num_wr    (num_wr),
    .num_word  (num_word),
    .st_merged (st_merged),
    .word_q    (word_q),
    .acc_mode  (acc_mode),
    .succ_dir  (succ_dir),
    .kind      (kind)
);

// File: tb/cell_acc_reg_bench.sv
module cell_acc_reg_bench;

    localparam int NLEN  = 4;
    localparam int NPORT = 4;
    localparam int W     = NLEN + 12;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_load;
    logic [W-1:0]       in_word;
    logic [NPORT-1:0]   st_valid;
    logic [NPORT*W-1:0] st_word;
    logic               num_wr;
    logic [W-1:0]       num_word;
    logic [W-1:0]       word_q;
    logic               acc_mode;
    logic               origin_mode;
    logic [1:0]         succ_dir;
    logic               fwd_req;
    logic               acc_neg;

    int n_checks = 0;
    int n_errors = 0;

    logic [W-1:0] m_word;
    logic         m_acc;
    logic [1:0]   m_dir;

    always #2 clk = ~clk;

    cell_acc_reg #(.NLEN(NLEN), .NPORT(NPORT)) u_cell_acc_reg (
        .clk         (clk),
        .rst         (rst),
        .in_load     (in_load),
        .in_word     (in_word),
        .st_valid    (st_valid),
        .st_word     (st_word),
        .num_wr      (num_wr),
        .num_word    (num_word),
        .word_q      (word_q),
        .acc_mode    (acc_mode),
        .origin_mode (origin_mode),
        .succ_dir    (succ_dir),
        .fwd_req     (fwd_req),
        .acc_neg     (acc_neg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk(input int y, input int pa, input int sd, input int rest);
        logic [W-1:0] w;
        w = '0;
        w[W-1:11] = y[NLEN:0];
        w[10:6]   = rest[4:0];
        w[5:4]    = sd[1:0];
        w[3:2]    = rest[6:5];
        w[1:0]    = pa[1:0];
        return w;
    endfunction

    task automatic check_outputs(input string tag);
        logic exp_org;
        exp_org = m_word[1] && !m_acc;
        chk({tag, " word R6/R7"}, 32'(word_q), 32'(m_word));
        chk({tag, " acc R2/R5"}, 32'(acc_mode), 32'(m_acc));
        chk({tag, " origin R3"}, 32'(origin_mode), 32'(exp_org));
        chk({tag, " dir R4"}, 32'(succ_dir), 32'(m_acc ? m_dir : m_word[5:4]));
        chk({tag, " fwd R8"}, 32'(fwd_req), 32'(m_acc || exp_org));
        chk({tag, " neg R9"}, 32'(acc_neg), 32'(m_acc && m_word[W-1]));
    endtask

    task automatic step(input string tag, input logic ld, input logic [W-1:0] lw,
                        input logic [NPORT-1:0] sv, input logic [NPORT*W-1:0] sw,
                        input logic nw, input logic [W-1:0] nword);
        logic [W-1:0] mrg;
        @(negedge clk);
        in_load = ld; in_word = lw; st_valid = sv; st_word = sw;
        num_wr = nw; num_word = nword;
        mrg = '0;
        for (int k = 0; k < NPORT; k++) if (sv[k]) mrg = mrg | sw[k*W +: W];
        if (ld) begin
            m_word = lw;
            m_acc  = (lw[1:0] == 2'b01);
            if (m_acc) m_dir = lw[5:4];
        end else if (sv != '0) begin
            if (!(m_acc && mrg[1:0] == 2'b01)) begin
                m_word = mrg;
                m_acc  = (mrg[1:0] == 2'b01);
                if (m_acc) m_dir = mrg[5:4];
            end
        end else if (nw && m_acc) begin
            m_word = nword;
        end
        @(posedge clk);
        #1;
        in_load = 1'b0; st_valid = '0; num_wr = 1'b0;
        check_outputs(tag);
    endtask

    initial begin : watchdog
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [NPORT*W-1:0] sw;
        rst = 1'b1; in_load = 1'b0; in_word = '0; st_valid = '0; st_word = '0;
        num_wr = 1'b0; num_word = '0;
        m_word = '0; m_acc = 1'b0; m_dir = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_outputs("reset R1");
        step("idle R1", 1'b0, '0, '0, '0, 1'b0, '0);

        // Sweep: start state x (p,a) x successor code x write path (R2 R3 R5 R6 R7)
        for (int st = 0; st < 2; st++) begin
            for (int pa = 0; pa < 4; pa++) begin
                for (int sd = 0; sd < 4; sd++) begin
                    for (int path = 0; path < 3; path++) begin
                        step("setup R6", 1'b1, mk(5 + sd, st ? 1 : 0, 3 - sd, 9), '0, '0, 1'b0, '0);
                        sw = '0;
                        if (path == 0) begin
                            step("load R6", 1'b1, mk(pa * 7 + sd, pa, sd, 3 * sd), '0, '0, 1'b0, '0);
                        end else if (path == 1) begin
                            sw[2*W +: W] = mk(17 + pa, pa, sd, 5);
                            sw[0 +: W]   = mk(31, 3, 3, 127);
                            step("store1 R5", 1'b0, '0, 4'b0100, sw, 1'b0, '0);
                        end else begin
                            sw[0 +: W]   = mk(sd, pa & 1, sd & 2, 0);
                            sw[1*W +: W] = mk(8, pa & 2, sd & 1, 64);
                            sw[3*W +: W] = mk(16, 0, 0, 2);
                            step("storeN R7", 1'b0, '0, 4'b1011, sw, 1'b0, '0);
                        end
                        step("hold R1", 1'b0, '0, '0, '0, 1'b0, '0);
                    end
                end
            end
        end

        // Load beats stores and numeric write in the same step (R6)
        sw = '0;
        sw[0 +: W] = mk(3, 1, 2, 0);
        step("prio R6", 1'b1, mk(2, 0, 1, 4), 4'b0001, sw, 1'b1, mk(9, 1, 3, 0));

        // Numeric write ignored on a normal cell (R10)
        step("num normal R10", 1'b0, '0, '0, '0, 1'b1, mk(31, 1, 3, 127));

        // Accumulator: numeric write with p=1, different s bits, negative sign (R10 R3 R4 R9)
        step("enter R2", 1'b1, mk(6, 1, 2, 0), '0, '0, 1'b0, '0);
        step("num acc R10", 1'b0, '0, '0, '0, 1'b1, mk(16 + 3, 2, 1, 33));
        step("num acc2 R10", 1'b0, '0, '0, '0, 1'b1, mk(16, 3, 0, 1));
        step("hold acc R4", 1'b0, '0, '0, '0, 1'b0, '0);

        // Rejected store, then accepted store leaving the status (R5)
        sw = '0;
        sw[1*W +: W] = mk(1, 1, 3, 0);
        step("reject R5", 1'b0, '0, 4'b0010, sw, 1'b0, '0);
        sw[1*W +: W] = mk(1, 0, 3, 0);
        step("accept R5", 1'b0, '0, 4'b0010, sw, 1'b0, '0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule